// File: doc/BRIEF.md
# SCSI Target Bus Phase Sequencer

This block is the phase controller of a SCSI target. It watches the bus for its own selection and, once selected, raises BSY. It then walks the information-transfer phases in a fixed order: COMMAND, an optional DATA phase in either direction, STATUS, and MESSAGE IN. It drives the C/D, I/O and MSG lines for each phase and finally releases BSY so that the bus returns to Bus Free.

Individual bytes are not handshaked here. Each byte is handed to a separate REQ/ACK transfer engine through a one-cycle start pulse and a done pulse. The engine reads the current direction from `io_o`.

The sequencer decides how long the command is from the group code in the top three bits of the first command byte. A user interface supplies three values: the data direction, the data byte count and the status byte. Received command and data bytes are presented on a byte strobe, and each byte sent in DATA IN is acknowledged with a take pulse.

Top module: `scsi_tgt_seq`

## Requirements
- R1: While reset is asserted and directly after it, `bsy_o`, `cd_o`, `io_o`, `msg_o`, `xfer_start_o`, `rx_stb_o` and `tx_take_o` are all 0.
- R2: Selection requires four conditions to hold together on `SETTLE_CYC` consecutive clock edges. The conditions are: `sel_i` is 1, `db_i[MY_ID]` is 1, `db_i` has at most two bits set, and both `bsy_i` and `io_i` are 0. `bsy_o` rises on the edge that completes this count. A shorter or interrupted run, a wrong ID bit, three or more set ID bits, or a high `bsy_i` or `io_i` causes no selection.
- R3: Phase codes on {`cd_o`,`io_o`,`msg_o`} are 100 for COMMAND, 010 for DATA IN, 000 for DATA OUT, 110 for STATUS and 111 for MESSAGE IN. These lines are 0 whenever `bsy_o` is 0. Phases occur only in the order COMMAND, DATA, STATUS, MESSAGE IN. COMMAND is entered on selection, and no transfer starts while `sel_i` is still 1.
- R4: Bits [7:5] of the first command byte select the command length: group 0 gives 6 bytes, groups 1 and 2 give 10 bytes, and group 5 gives 12 bytes.
- R5: Any other group code ends COMMAND after the first byte. The block skips DATA and sends status 0x02.
- R6: After the last command byte, `usr_dir_i` (1 = DATA IN) and `usr_len_i` are sampled. DATA IN sends `usr_len_i` bytes taken from `usr_tx_i`, with one `tx_take_o` pulse per byte. DATA OUT receives `usr_len_i` bytes on `rx_stb_o` with `rx_cmd_o` at 0. A length of 0 skips DATA.
- R7: STATUS sends exactly one byte. That byte is `usr_status_i`, sampled on entry to STATUS.
- R8: MESSAGE IN sends exactly one byte, 0x00.
- R9: On the clock edge that completes the message byte, `bsy_o` and all three phase lines fall to 0.
- R10: `xfer_start_o` is a one-cycle pulse. The phase lines hold steady from the cycle before a start until that byte's done.
- R11: Each received command byte appears on `rx_byte_o` with `rx_stb_o` and `rx_cmd_o` both at 1, one cycle after its done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | SEL as seen on the bus |
| bsy_i | input | 1 | BSY driven by other devices |
| io_i | input | 1 | I/O as seen on the bus |
| db_i | input | 8 | Bus data bits, sampled for IDs |
| bsy_o | output | 1 | BSY driven by this target |
| cd_o | output | 1 | C/D phase line |
| io_o | output | 1 | I/O phase line, 1 = target sends |
| msg_o | output | 1 | MSG phase line |
| xfer_start_o | output | 1 | Starts one byte on the transfer engine |
| xfer_byte_o | output | 8 | Byte to send while `io_o` is 1 |
| xfer_done_i | input | 1 | Engine finished the byte |
| xfer_byte_i | input | 8 | Byte received by the engine |
| usr_dir_i | input | 1 | Data direction, 1 = DATA IN |
| usr_len_i | input | LEN_W | Data byte count |
| usr_status_i | input | 8 | Status byte |
| usr_tx_i | input | 8 | Next DATA IN byte |
| tx_take_o | output | 1 | DATA IN byte consumed |
| rx_byte_o | output | 8 | Received byte |
| rx_stb_o | output | 1 | Received byte valid |
| rx_cmd_o | output | 1 | Received byte belongs to the command |

## Verification
The hardest behaviour to reach from the ports is where the command length is resolved. It depends on a byte that only arrives through a completed transfer, and each group code sends the sequence down a different branch. A stimulus table drives complete transactions for every supported group code, for two unsupported ones, and for both data directions and a zero length. A bench-side engine answers each start pulse and logs the phase code, so the order of phases and the byte counts in each phase can be compared. Directed runs cover selection attempts that are one cycle short, interrupted, or spoiled by a wrong ID, extra ID bits, or a busy bus.

// File: rtl/scsi_tgt_seq.sv
module scsi_tgt_seq #(
  parameter int MY_ID      = 3,
  parameter int SETTLE_CYC = 4,
  parameter int LEN_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_i,
  input  logic             bsy_i,
  input  logic             io_i,
  input  logic [7:0]       db_i,
  output logic             bsy_o,
  output logic             cd_o,
  output logic             io_o,
  output logic             msg_o,
  output logic             xfer_start_o,
  output logic [7:0]       xfer_byte_o,
  input  logic             xfer_done_i,
  input  logic [7:0]       xfer_byte_i,
  input  logic             usr_dir_i,
  input  logic [LEN_W-1:0] usr_len_i,
  input  logic [7:0]       usr_status_i,
  input  logic [7:0]       usr_tx_i,
  output logic             tx_take_o,
  output logic [7:0]       rx_byte_o,
  output logic             rx_stb_o,
  output logic             rx_cmd_o
);

  localparam int SC_W = $clog2(SETTLE_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_DATA, S_STAT, S_MSG} st_t;

  st_t              st;
  logic             busy, start_q, dir_q;
  logic [SC_W-1:0]  scnt;
  logic [LEN_W-1:0] bcnt, len_q;
  logic [3:0]       clen;
  logic [7:0]       stat_q;

  logic             sel_ok, can_go, done;
  logic [LEN_W-1:0] bnext;
  logic [3:0]       grp_len;

  assign sel_ok = sel_i && db_i[MY_ID] && !bsy_i && !io_i && ($countones(db_i) <= 2);
  assign can_go = (st != S_IDLE) && !busy && !(st == S_CMD && sel_i);
  assign done   = busy && xfer_done_i;
  assign bnext  = bcnt + 1'b1;

  always_comb begin
    case (xfer_byte_i[7:5])
      3'd0:       grp_len = 4'd6;
      3'd1, 3'd2: grp_len = 4'd10;
      3'd5:       grp_len = 4'd12;
      default:    grp_len = 4'd0;
    endcase
  end

  assign bsy_o        = (st != S_IDLE);
  assign cd_o         = (st == S_CMD) || (st == S_STAT) || (st == S_MSG);
  assign io_o         = (st == S_DATA && dir_q) || (st == S_STAT) || (st == S_MSG);
  assign msg_o        = (st == S_MSG);
  assign xfer_start_o = start_q;
  assign xfer_byte_o  = (st == S_DATA) ? usr_tx_i : (st == S_STAT) ? stat_q : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      busy      <= 1'b0;
      start_q   <= 1'b0;
      dir_q     <= 1'b0;
      scnt      <= '0;
      bcnt      <= '0;
      len_q     <= '0;
      clen      <= 4'd0;
      stat_q    <= 8'h00;
      rx_byte_o <= 8'h00;
      rx_stb_o  <= 1'b0;
      rx_cmd_o  <= 1'b0;
      tx_take_o <= 1'b0;
    end else begin
      start_q   <= can_go;
      rx_stb_o  <= 1'b0;
      rx_cmd_o  <= 1'b0;
      tx_take_o <= 1'b0;
      if (can_go) busy <= 1'b1;

      if (st == S_IDLE) begin
        if (!sel_ok) begin
          scnt <= '0;
        end else if (scnt == SC_W'(SETTLE_CYC - 1)) begin
          st    <= S_CMD;
          scnt  <= '0;
          bcnt  <= '0;
          dir_q <= 1'b0;
        end else begin
          scnt <= scnt + 1'b1;
        end
      end

      if (done) begin
        busy <= 1'b0;
        unique case (st)
          S_CMD: begin
            rx_byte_o <= xfer_byte_i;
            rx_stb_o  <= 1'b1;
            rx_cmd_o  <= 1'b1;
            if (bcnt == '0 && grp_len == 4'd0) begin
              st     <= S_STAT;
              stat_q <= 8'h02;
            end else if (bcnt == '0) begin
              clen <= grp_len;
              bcnt <= bnext;
            end else if (bnext == {{(LEN_W-4){1'b0}}, clen}) begin
              dir_q <= usr_dir_i;
              len_q <= usr_len_i;
              bcnt  <= '0;
              if (usr_len_i == '0) begin
                st     <= S_STAT;
                stat_q <= usr_status_i;
              end else begin
                st <= S_DATA;
              end
            end else begin
              bcnt <= bnext;
            end
          end
          S_DATA: begin
            if (!dir_q) begin
              rx_byte_o <= xfer_byte_i;
              rx_stb_o  <= 1'b1;
            end
            tx_take_o <= dir_q;
            if (bnext == len_q) begin
              st     <= S_STAT;
              stat_q <= usr_status_i;
            end else begin
              bcnt <= bnext;
            end
          end
          S_STAT:  st <= S_MSG;
          S_MSG:   st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/scsi_tgt_seq_chk.sv
module scsi_tgt_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic sel_ok,
  input logic sel_i,
  input logic bsy_o,
  input logic cd_o,
  input logic io_o,
  input logic msg_o,
  input logic xfer_start_o,
  input logic busy
);

  a_r2_bsy_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bsy_o) |-> $past(sel_ok));

  a_r3_lines_need_bsy: assert property (@(posedge clk) disable iff (!rst_n)
    (cd_o || io_o || msg_o) |-> bsy_o);

  a_r3_no_start_during_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start_o && cd_o && !io_o) |-> !$past(sel_i));

  a_r8_msg_code: assert property (@(posedge clk) disable iff (!rst_n)
    msg_o |-> (cd_o && io_o));

  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bsy_o) |-> ($past(msg_o) && !cd_o && !io_o && !msg_o));

  a_r10_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start_o |=> !xfer_start_o);

  a_r10_stable_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start_o |-> $stable({cd_o, io_o, msg_o}));

  a_r10_stable_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable({cd_o, io_o, msg_o}));

endmodule

bind scsi_tgt_seq scsi_tgt_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel_ok(sel_ok), .sel_i(sel_i), .bsy_o(bsy_o),
  .cd_o(cd_o), .io_o(io_o), .msg_o(msg_o), .xfer_start_o(xfer_start_o), .busy(busy)
);

// File: tb/scsi_tgt_seq_test.sv
module scsi_tgt_seq_test;
  localparam int CLK_PER = 10;
  localparam int MY_ID   = 3;
  localparam int SETTLE  = 4;
  localparam int LEN_W   = 16;

  // {opcode, dir, len, status, cmd bytes, data bytes}
  localparam logic [47:0] VEC [6] = '{
    {8'h08, 8'd1, 8'd3, 8'h00, 8'd6,  8'd3},
    {8'h2A, 8'd0, 8'd2, 8'h00, 8'd10, 8'd2},
    {8'h48, 8'd1, 8'd0, 8'h08, 8'd10, 8'd0},
    {8'hA8, 8'd0, 8'd1, 8'h18, 8'd12, 8'd1},
    {8'h60, 8'd1, 8'd4, 8'h00, 8'd1,  8'd0},
    {8'hE0, 8'd0, 8'd4, 8'h00, 8'd1,  8'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_i = 1'b0, bsy_i = 1'b0, io_i = 1'b0;
  logic [7:0] db_i = 8'h00;
  logic bsy_o, cd_o, io_o, msg_o, xfer_start_o, tx_take_o, rx_stb_o, rx_cmd_o;
  logic [7:0] xfer_byte_o, rx_byte_o;
  logic xfer_done_i = 1'b0;
  logic [7:0] xfer_byte_i = 8'h00;
  logic usr_dir_i = 1'b0;
  logic [LEN_W-1:0] usr_len_i = '0;
  logic [7:0] usr_status_i = 8'h00, usr_tx_i = 8'h5A;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PER/2) clk = ~clk;

  scsi_tgt_seq #(.MY_ID(MY_ID), .SETTLE_CYC(SETTLE), .LEN_W(LEN_W)) uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic no_select(input logic [7:0] db, input logic bi, input logic ii, input int cyc, input string req);
    @(negedge clk);
    sel_i = 1'b1; db_i = db; bsy_i = bi; io_i = ii;
    repeat (cyc) @(negedge clk);
    chk(!bsy_o, req, bsy_o, 0);
    sel_i = 1'b0; db_i = 8'h00; bsy_i = 1'b0; io_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_txn(input logic [47:0] v);
    logic [7:0] op, st, rb, sent, got_stat, got_msg;
    logic [2:0] ph;
    int ncmd, ndata, cyc, wd, ord, o, c_cmd, c_data, c_stat, c_msg;
    op = v[47:40]; st = v[23:16]; ncmd = int'(v[15:8]); ndata = int'(v[7:0]);
    usr_dir_i = v[32]; usr_len_i = LEN_W'(v[31:24]); usr_status_i = st;
    c_cmd = 0; c_data = 0; c_stat = 0; c_msg = 0; ord = 0;
    got_stat = 8'hFF; got_msg = 8'hFF;
    @(negedge clk);
    sel_i = 1'b1; db_i = 8'h80 | (8'h01 << MY_ID);
    cyc = 0;
    while (!bsy_o && cyc < 20) begin @(negedge clk); cyc++; end
    chk(cyc == SETTLE, "R2 selection latency", cyc, SETTLE);
    chk({cd_o, io_o, msg_o} == 3'b100, "R3 command phase code", {cd_o, io_o, msg_o}, 3'b100);
    for (int i = 0; i < 3; i++) begin
      chk(!xfer_start_o, "R3 no start while SEL held", xfer_start_o, 0);
      @(negedge clk);
    end
    sel_i = 1'b0; db_i = 8'h00;
    forever begin
      wd = 0;
      while (!xfer_start_o && bsy_o && wd < 100) begin @(negedge clk); wd++; end
      if (!bsy_o) break;
      if (wd >= 100) begin chk(1'b0, "R10 start timeout", wd, 0); break; end
      ph = {cd_o, io_o, msg_o}; sent = xfer_byte_o;
      @(negedge clk);
      chk(!xfer_start_o, "R10 start is one cycle", xfer_start_o, 0);
      @(negedge clk);
      chk({cd_o, io_o, msg_o} == ph, "R10 lines steady in transfer", {cd_o, io_o, msg_o}, ph);
      rb = (ph == 3'b100) ? ((c_cmd == 0) ? op : 8'(c_cmd)) : (ph == 3'b000) ? 8'(8'hC0 + c_data) : 8'h00;
      xfer_done_i = 1'b1; xfer_byte_i = rb;
      @(negedge clk);
      xfer_done_i = 1'b0;
      o = 0;
      case (ph)
        3'b100: begin
          chk(rx_stb_o && rx_cmd_o && rx_byte_o == rb, "R11 command byte strobe", rx_byte_o, rb);
          c_cmd++; o = 0;
        end
        3'b010: begin
          chk(sent == usr_tx_i && tx_take_o, "R6 DATA IN byte and take", sent, usr_tx_i);
          c_data++; o = 1;
        end
        3'b000: begin
          chk(rx_stb_o && !rx_cmd_o && rx_byte_o == rb, "R6 DATA OUT byte strobe", rx_byte_o, rb);
          c_data++; o = 1;
        end
        3'b110: begin got_stat = sent; c_stat++; o = 2; end
        3'b111: begin
          got_msg = sent; c_msg++; o = 3;
          chk(!bsy_o && !cd_o && !io_o && !msg_o, "R9 release after message",
              {bsy_o, cd_o, io_o, msg_o}, 0);
        end
        default: chk(1'b0, "R3 illegal phase code", ph, 0);
      endcase
      chk(o >= ord, "R3 phase order", o, ord);
      ord = o;
    end
    chk(c_cmd == ncmd, (ncmd == 1) ? "R5 unsupported group stops after one byte" : "R4 command length",
        c_cmd, ncmd);
    chk(c_data == ndata, (ncmd == 1) ? "R5 no data phase" : "R6 data byte count", c_data, ndata);
    chk(c_stat == 1, "R7 one status byte", c_stat, 1);
    chk(got_stat == ((ncmd == 1) ? 8'h02 : st), (ncmd == 1) ? "R5 check condition status" : "R7 status value",
        got_stat, (ncmd == 1) ? 8'h02 : st);
    chk(c_msg == 1 && got_msg == 8'h00, "R8 single 0x00 message", got_msg, 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({bsy_o, cd_o, io_o, msg_o, xfer_start_o, rx_stb_o, tx_take_o} == 7'b0, "R1 outputs in reset",
        {bsy_o, cd_o, io_o, msg_o, xfer_start_o, rx_stb_o, tx_take_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({bsy_o, cd_o, io_o, msg_o, xfer_start_o} == 5'b0, "R1 outputs after reset",
        {bsy_o, cd_o, io_o, msg_o, xfer_start_o}, 0);

    for (int i = 0; i < 6; i++) run_txn(VEC[i]);

    no_select(8'h81, 1'b0, 1'b0, SETTLE + 4, "R2 wrong ID bit ignored");
    no_select(8'h89 | (8'h01 << MY_ID), 1'b0, 1'b0, SETTLE + 4, "R2 three ID bits ignored");
    no_select(8'h80 | (8'h01 << MY_ID), 1'b1, 1'b0, SETTLE + 4, "R2 busy bus blocks selection");
    no_select(8'h80 | (8'h01 << MY_ID), 1'b0, 1'b1, SETTLE + 4, "R2 I/O high blocks selection");
    no_select(8'h80 | (8'h01 << MY_ID), 1'b0, 1'b0, SETTLE - 1, "R2 short SEL ignored");
    sel_i = 1'b1; db_i = 8'h80 | (8'h01 << MY_ID);
    repeat (SETTLE - 1) @(negedge clk);
    sel_i = 1'b0;
    @(negedge clk);
    sel_i = 1'b1;
    repeat (SETTLE - 1) @(negedge clk);
    chk(!bsy_o, "R2 interrupted SEL restarts count", bsy_o, 0);
    sel_i = 1'b0; db_i = 8'h00;
    repeat (2) @(negedge clk);

    run_txn(VEC[0]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule